// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of phase samples, as produced by a rectangular-to-polar stage, into frequency estimates. Each accepted phase sample is first scaled by a power of two (a left shift that wraps modulo one full turn), which can strip a known phase modulation. The block then subtracts the scaled sample taken a programmable number of samples earlier. The difference is a frequency estimate, and the block keeps one difference out of every N.

A single 32-bit control word sets the scale, the lag, the decimation factor and an enable. The control word is read combinationally on every clock. The phase input is a 16-bit two's-complement value qualified by a valid strobe. The output is a 16-bit frequency value with its own valid strobe, and it is registered. The whole block runs on one processing clock and has a synchronous active-high reset.

Top module: `freq_disc`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `freq_vld` is 0 and `freq_out` is 0.
- R2: Control bits 16:15 hold a shift code m. Each accepted phase is shifted left by m bits before any other use. The upper bits fall off and the low bits fill with zeros, which multiplies the phase by 2^m modulo 2^16.
- R3: Control bits 2:0 hold a lag code d. The output value is the scaled current sample minus the scaled sample accepted d+1 samples earlier, reduced modulo 2^16 so that a phase wrap gives a small result. Samples from before the last enable count as zero.
- R4: Control bits 13:11 hold a decimation code c. The factor N is 8 when c is 0 and c otherwise. Only the Nth, 2Nth, ... accepted sample after enabling produces a `freq_vld` pulse.
- R5: Control bit 14 is the enable. While it is 0, `freq_vld` stays 0, and the sample history and the decimation count both return to zero.
- R6: When the decimation code differs from its value in the previous cycle, the decimation count restarts, and the sample in that cycle counts as the first of a new group.
- R7: A cycle with `phase_vld` low is ignored. It produces no output and does not advance the history or the decimation count.
- R8: When an accepted sample produces an output, `freq_vld` and `freq_out` show it in the cycle after the sample is presented.
- R9: Control bits 31:17 and 10:3 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 32 | Configuration: shift, enable, decimation, lag |
| phase_vld | input | 1 | Phase sample is valid this cycle |
| phase_in | input | 16 | Phase sample, two's complement, one turn = 2^16 |
| freq_vld | output | 1 | Frequency sample is valid |
| freq_out | output | 16 | Frequency sample, two's complement |

## Verification
The assertions assume that `phase_vld` and `ctrl_word` are driven to known values from the first clock. They also assume that the control word changes only between clock edges. The bench drives both inputs at the falling edge and holds `phase_vld` low during reset. The bench sweeps every combination of shift, lag and decimation code. Within each combination it inserts idle cycles and phase values near the wrap point, so every stimulus stays inside what the assertions assume.

// File: rtl/freq_disc_pkg.sv
package freq_disc_pkg;

  localparam int CTRL_W     = 32;
  localparam int MUL_LSB    = 15;
  localparam int EN_BIT     = 14;
  localparam int DEC_LSB    = 11;
  localparam int LAG_LSB    = 0;
  localparam int MUL_FLD_W  = 2;
  localparam int DEC_FLD_W  = 3;
  localparam int LAG_FLD_W  = 3;

  typedef struct packed {
    logic [MUL_FLD_W-1:0] mul;
    logic                 en;
    logic [DEC_FLD_W-1:0] dec;
    logic [LAG_FLD_W-1:0] lag;
  } fd_cfg_t;

  function automatic fd_cfg_t fd_decode(input logic [CTRL_W-1:0] w);
    fd_cfg_t c;
    c.mul = w[MUL_LSB +: MUL_FLD_W];
    c.en  = w[EN_BIT];
    c.dec = w[DEC_LSB +: DEC_FLD_W];
    c.lag = w[LAG_LSB +: LAG_FLD_W];
    return c;
  endfunction

  // Code 0 selects the largest factor; other codes are the factor itself.
  function automatic logic [DEC_FLD_W:0] fd_dec_factor(input logic [DEC_FLD_W-1:0] f);
    logic [DEC_FLD_W:0] r;
    if (f == '0) r = {1'b1, {DEC_FLD_W{1'b0}}};
    else         r = {1'b0, f};
    return r;
  endfunction

endpackage

// File: rtl/fd_prescale.sv
module fd_prescale #(
  parameter int PHASE_W = 16,
  parameter int MUL_W   = 2
) (
  input  logic [PHASE_W-1:0] phase_raw,
  input  logic [MUL_W-1:0]   mul_code,
  output logic [PHASE_W-1:0] phase_scaled
);

  localparam int N_SHIFT = 1 << MUL_W;

  logic [PHASE_W-1:0] cand [N_SHIFT];

  genvar s;
  generate
    for (s = 0; s < N_SHIFT; s++) begin : g_shift
      assign cand[s] = phase_raw << s;
    end
  endgenerate

  assign phase_scaled = cand[mul_code];

  always_comb begin
    a_low_zero_r2: assert (mul_code == '0 || phase_scaled[0] == 1'b0);
  end

endmodule

// File: rtl/fd_lag_diff.sv
module fd_lag_diff #(
  parameter int PHASE_W = 16,
  parameter int DEPTH   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     accept,
  input  logic [PHASE_W-1:0]       sample_in,
  input  logic [$clog2(DEPTH)-1:0] lag_sel,
  output logic [PHASE_W-1:0]       diff_out
);

  localparam int SEL_W = $clog2(DEPTH);

  // Modular subtraction: a wrap of the phase gives the short-way difference.
  function automatic logic [PHASE_W-1:0] wrap_sub(input logic [PHASE_W-1:0] a,
                                                  input logic [PHASE_W-1:0] b);
    return a - b;
  endfunction

  logic [PHASE_W-1:0] hist_q [DEPTH];
  logic [PHASE_W-1:0] tap_sel;
  logic [SEL_W-1:0]   sel_w;

  assign sel_w = lag_sel;

  genvar t;
  generate
    for (t = 0; t < DEPTH; t++) begin : g_hist
      logic [PHASE_W-1:0] feed;
      if (t == 0) begin : g_head
        assign feed = sample_in;
      end else begin : g_body
        assign feed = hist_q[t-1];
      end
      always_ff @(posedge clk) begin
        if (rst || clear)   hist_q[t] <= '0;
        else if (accept)    hist_q[t] <= feed;
      end
    end
  endgenerate

  assign tap_sel  = hist_q[sel_w];
  assign diff_out = wrap_sub(sample_in, tap_sel);

  p_hist_head_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !clear) |=> (hist_q[0] == $past(sample_in)));

  p_hist_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!accept && !clear) |=> $stable(hist_q[DEPTH-1]));

  p_hist_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (hist_q[0] == '0 && hist_q[DEPTH-1] == '0));

endmodule

// File: rtl/fd_decim.sv
module fd_decim #(
  parameter int DEC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             accept,
  input  logic [DEC_W-1:0] field,
  output logic             fire
);
  import freq_disc_pkg::*;

  localparam int CNT_W = DEC_W;

  logic [DEC_W-1:0] field_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic [DEC_W:0]   factor;
  logic             field_moved;
  logic             at_last;

  assign factor      = fd_dec_factor(field);
  assign field_moved = (field != field_q);
  assign cnt_eff     = field_moved ? '0 : cnt_q;
  assign at_last     = ({1'b0, cnt_eff} == factor - 1'b1);
  assign fire        = accept && !clear && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
      cnt_q   <= '0;
    end else begin
      field_q <= field;
      if (clear)        cnt_q <= '0;
      else if (accept)  cnt_q <= at_last ? '0 : cnt_eff + 1'b1;
      else              cnt_q <= cnt_eff;
    end
  end

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, cnt_q} < fd_dec_factor(field_q)));

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (field != field_q && !accept) |=> (cnt_q == '0));

endmodule

// File: rtl/freq_disc.sv
module freq_disc #(
  parameter int PHASE_W = 16,
  parameter int DEPTH   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ctrl_word,
  input  logic        phase_vld,
  input  logic [15:0] phase_in,
  output logic        freq_vld,
  output logic [15:0] freq_out
);
  import freq_disc_pkg::*;

  fd_cfg_t            cfg;
  logic               accept;
  logic               clear;
  logic [PHASE_W-1:0] scaled;
  logic [PHASE_W-1:0] diff;
  logic               fire;

  assign cfg    = fd_decode(ctrl_word);
  assign accept = phase_vld && cfg.en;
  assign clear  = !cfg.en;

  fd_prescale #(.PHASE_W(PHASE_W), .MUL_W(MUL_FLD_W)) u_scale (
    .phase_raw   (phase_in),
    .mul_code    (cfg.mul),
    .phase_scaled(scaled)
  );

  fd_lag_diff #(.PHASE_W(PHASE_W), .DEPTH(DEPTH)) u_lag (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .accept   (accept),
    .sample_in(scaled),
    .lag_sel  (cfg.lag),
    .diff_out (diff)
  );

  fd_decim #(.DEC_W(DEC_FLD_W)) u_dec (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .accept(accept),
    .field (cfg.dec),
    .fire  (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_vld <= 1'b0;
      freq_out <= '0;
    end else begin
      freq_vld <= fire;
      if (fire) freq_out <= diff;
    end
  end

  p_vld_after_sample_r8: assert property (@(posedge clk) disable iff (rst)
    freq_vld |-> $past(phase_vld && ctrl_word[EN_BIT]));

  p_disabled_silent_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_word[EN_BIT] |=> !freq_vld);

  p_unit_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_vld && ctrl_word[EN_BIT] && ctrl_word[DEC_LSB +: DEC_FLD_W] == 3'd1) |=> freq_vld);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !phase_vld |=> !freq_vld);

endmodule

// File: tb/freq_disc_bench.sv
module freq_disc_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl_word = '0;
  logic        phase_vld = 1'b0;
  logic [15:0] phase_in = '0;
  logic        freq_vld;
  logic [15:0] freq_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] m_hist [8];
  int          m_cnt  = 0;
  logic [2:0]  m_prev = '0;

  always #4 clk = ~clk;

  freq_disc u_freq_disc (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .phase_vld(phase_vld),
    .phase_in(phase_in), .freq_vld(freq_vld), .freq_out(freq_out)
  );

  function automatic logic [31:0] mk(input int mul, input int en, input int dec,
                                     input int lag, input logic [22:0] junk);
    logic [31:0] w;
    w = '0;
    w[31:17] = junk[22:8];
    w[10:3]  = junk[7:0];
    w[16:15] = 2'(mul);
    w[14]    = 1'(en);
    w[13:11] = 3'(dec);
    w[2:0]   = 3'(lag);
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: model the requirements, drive at the falling edge, compare one edge later.
  task automatic step(input logic [31:0] w, input logic v, input logic [15:0] p, input string tag);
    logic        ev;
    logic [15:0] ed;
    logic [15:0] sh;
    int          n;
    ev = 1'b0;
    ed = '0;
    if (!w[14]) begin
      for (int i = 0; i < 8; i++) m_hist[i] = '0;
      m_cnt = 0;
    end else begin
      if (w[13:11] != m_prev) m_cnt = 0;
      n = (w[13:11] == 3'd0) ? 8 : int'(w[13:11]);
      if (v) begin
        sh = p << w[16:15];
        ed = sh - m_hist[w[2:0]];
        for (int i = 7; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = sh;
        if (m_cnt == n - 1) begin ev = 1'b1; m_cnt = 0; end
        else m_cnt++;
      end
    end
    m_prev = w[13:11];
    ctrl_word = w;
    phase_vld = v;
    phase_in  = p;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, {15'd0, freq_vld}, {15'd0, ev});
    if (ev) check({tag, " value"}, freq_out, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_hist[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {15'd0, freq_vld}, 16'd0);
    check("R1 reset data", freq_out, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset valid", {15'd0, freq_vld}, 16'd0);
    check("R1 after reset data", freq_out, 16'd0);

    // Full sweep of shift, lag and decimation codes (R2, R3, R4, R5, R7).
    for (int mu = 0; mu < 4; mu++)
      for (int lg = 0; lg < 8; lg++)
        for (int dc = 0; dc < 8; dc++) begin
          step(mk(mu, 0, dc, lg, '0), 1'b1, 16'h1234, "R5 disabled");
          for (int k = 0; k < 14; k++) begin
            logic [15:0] ph;
            ph = 16'h7F00 + 16'(k * 16'h2F1D) + 16'(mu * 16'h0913) + 16'(lg * 16'h1111);
            step(mk(mu, 1, dc, lg, '0), (k % 5) != 3, ph, "R2 R3 R4 R7 sweep");
          end
        end

    // Wrap through the sign boundary with unit lag and no scaling (R3).
    step(mk(0, 0, 1, 0, '0), 1'b0, 16'h0000, "R5 disabled");
    step(mk(0, 1, 1, 0, '0), 1'b1, 16'h7FF0, "R3 wrap");
    step(mk(0, 1, 1, 0, '0), 1'b1, 16'h8010, "R3 wrap");
    check("R3 wrap small step", freq_out, 16'h0020);
    step(mk(0, 1, 1, 0, '0), 1'b1, 16'hFFF8, "R3 wrap");
    step(mk(0, 1, 1, 0, '0), 1'b1, 16'h0008, "R3 wrap");
    check("R3 wrap through zero", freq_out, 16'h0010);

    // Latency of one cycle (R8).
    step(mk(0, 1, 1, 0, '0), 1'b0, 16'h0000, "R8 idle");
    step(mk(0, 1, 1, 0, '0), 1'b1, 16'h0100, "R8 one cycle");

    // Decimation code change restarts the count (R6).
    step(mk(0, 0, 3, 0, '0), 1'b0, 16'h0000, "R5 disabled");
    step(mk(0, 1, 3, 0, '0), 1'b1, 16'h0010, "R6 group");
    step(mk(0, 1, 3, 0, '0), 1'b1, 16'h0020, "R6 group");
    step(mk(0, 1, 2, 0, '0), 1'b1, 16'h0030, "R6 restart first");
    step(mk(0, 1, 2, 0, '0), 1'b1, 16'h0040, "R6 restart second");
    check("R6 pulse after restart", {15'd0, freq_vld}, 16'd1);
    step(mk(0, 1, 3, 0, '0), 1'b0, 16'h0000, "R6 idle change");
    step(mk(0, 1, 3, 0, '0), 1'b1, 16'h0050, "R6 after idle change");
    step(mk(0, 1, 3, 0, '0), 1'b1, 16'h0060, "R6 after idle change");
    step(mk(0, 1, 3, 0, '0), 1'b1, 16'h0070, "R6 after idle change");

    // Reserved bits carry junk and change every cycle (R9).
    step(mk(1, 0, 2, 4, 23'h5A5A5A), 1'b0, 16'h0000, "R9 disabled");
    for (int k = 0; k < 24; k++)
      step(mk(1, 1, 2, 4, 23'(k * 23'h1B3D7)), 1'b1, 16'(k * 16'h0BCD + 16'h4000), "R9 reserved");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule